// File: doc/BRIEF.md
# Genome Bit-Flip Mutation Unit

This block holds a 672-bit genome and mutates it in place. A mutation run does not test each bit against a probability. It first draws a mutation count from a small weighted lookup. It then inverts that many bit positions, each picked at random, one position per clock cycle. A 16-bit maximal-length LFSR supplies every random value, and software or a neighbouring block can seed it.

A controller writes a genome while the unit is idle, pulses start, and waits for the one-cycle done pulse. It then reads the mutated genome from the output. Selection, crossover and fitness evaluation are handled elsewhere.

Top module: `genome_mutator`

## Requirements
- R1: After reset the genome register is all zero, busy and done are low, and the LFSR holds 16'hACE1.
- R2: While idle, gen_load copies gen_in into the genome register on the next edge. While busy, gen_load is ignored, and the genome at done reflects only the run's flips.
- R3: On an accepted start, the count is drawn from index k = (LFSR value) mod 10. Index 0 gives 1 flip, indices 1 to 6 give 2 flips, indices 7 and 8 give 3 flips, and index 9 gives 4 flips.
- R4: The LFSR shifts left with new bit 0 = s[15]^s[13]^s[12]^s[10]. It steps once on an accepted start and once in every busy cycle, and holds its value while idle.
- R5: In each busy cycle the low 10 LFSR bits form a position p. If p < 672, bit p of the genome is inverted and the remaining count drops by one. Otherwise nothing changes and p is redrawn on the next cycle. A position drawn twice is inverted twice.
- R6: On the edge that applies the last flip, busy falls and done rises. Done stays high for exactly one cycle.
- R7: A start pulse while busy is ignored.
- R8: While idle, seed_load loads seed_val into the LFSR, and a zero seed loads 16'hACE1 instead. seed_load wins over start in the same cycle, and that start is dropped. While busy, seed_load is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| seed_load | input | 1 | Load LFSR seed (idle only) |
| seed_val | input | 16 | Seed value |
| gen_load | input | 1 | Write genome (idle only) |
| gen_in | input | 672 | Genome write data |
| start | input | 1 | Begin a mutation run |
| gen_out | output | 672 | Current genome |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |

## Verification
Many seeded runs on random genomes cover every count-table index and many rejected positions. Each run is compared against an independent model for the final genome and for the exact number of busy cycles. A mismatch in cycle count points to errors in the count mapping or the rejection rule, while a genome mismatch points to wrong bit selection. Directed runs inject start, gen_load or seed_load in the first busy cycle to show that each is ignored. A zero seed and a seed that arrives together with start separate the seed substitution rule from the priority rule.

// File: rtl/genome_mutator.sv
module genome_mutator #(
  parameter int GENOME_W = 672,
  parameter logic [15:0] SEED_DEF = 16'hACE1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                seed_load,
  input  logic [15:0]         seed_val,
  input  logic                gen_load,
  input  logic [GENOME_W-1:0] gen_in,
  input  logic                start,
  output logic [GENOME_W-1:0] gen_out,
  output logic                busy,
  output logic                done
);
  localparam int POS_W = $clog2(GENOME_W);

  logic [15:0]         lfsr_q;
  logic [2:0]          rem_q;
  logic                busy_q, done_q;
  logic [GENOME_W-1:0] gen_q;

  wire [15:0]      lfsr_nx  = {lfsr_q[14:0], lfsr_q[15] ^ lfsr_q[13] ^ lfsr_q[12] ^ lfsr_q[10]};
  wire [3:0]       draw_idx = 4'(lfsr_q % 16'd10);
  wire [POS_W-1:0] pos      = lfsr_q[POS_W-1:0];
  wire             hit      = int'(pos) < GENOME_W;

  logic [2:0] count_pick;
  always_comb begin
    if (draw_idx == 4'd0)      count_pick = 3'd1;
    else if (draw_idx <= 4'd6) count_pick = 3'd2;
    else if (draw_idx <= 4'd8) count_pick = 3'd3;
    else                       count_pick = 3'd4;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lfsr_q <= SEED_DEF;
      rem_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      gen_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (gen_load) gen_q <= gen_in;
        if (seed_load) lfsr_q <= (seed_val == 16'd0) ? SEED_DEF : seed_val;
        else if (start) begin
          rem_q  <= count_pick;
          lfsr_q <= lfsr_nx;
          busy_q <= 1'b1;
        end
      end else begin
        lfsr_q <= lfsr_nx;
        if (hit) begin
          gen_q[pos] <= ~gen_q[pos];
          rem_q      <= rem_q - 3'd1;
          if (rem_q == 3'd1) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
          end
        end
      end
    end
  end

  assign gen_out = gen_q;
  assign busy    = busy_q;
  assign done    = done_q;

  a_r4_lfsr_nonzero: assert property (@(posedge clk) disable iff (!rst_n) lfsr_q != 16'd0);
  a_r3_count_range: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (rem_q >= 3'd1 && rem_q <= 3'd4));
  a_r5_single_flip: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |=> $countones(gen_q ^ $past(gen_q)) <= 1);
  a_r5_miss_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !hit) |=> $stable(gen_q));
  a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && !gen_load) |=> $stable(gen_q));
  a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n) done_q |=> !done_q);
  a_r6_done_on_fall: assert property (@(posedge clk) disable iff (!rst_n) $fell(busy_q) |-> done_q);
endmodule

// File: tb/genome_mutator_bench.sv
module genome_mutator_bench;
  localparam int GW = 672;
  logic clk = 0, rst_n = 0, seed_load = 0, gen_load = 0, start = 0;
  logic [15:0] seed_val = '0;
  logic [GW-1:0] gen_in = '0, gen_out;
  logic busy, done;
  int total = 0, bad = 0, cyc = 0;
  logic [15:0] m_lfsr;
  logic [GW-1:0] m_gen;

  genome_mutator u_genome_mutator (.clk, .rst_n, .seed_load, .seed_val, .gen_load,
    .gen_in, .start, .gen_out, .busy, .done);

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc >= 100000) begin
      bad++; total++;
      $display("FAIL watchdog: actual=%0d cycles expected<100000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string msg);
    total++;
    if (!ok) begin bad++; $display("FAIL %s", msg); end
  endtask

  function automatic logic [15:0] step(input logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

  function automatic int pick(input logic [15:0] s);
    int k = int'(s % 16'd10);
    if (k == 0) return 1;
    if (k <= 6) return 2;
    if (k <= 8) return 3;
    return 4;
  endfunction

  function automatic logic [GW-1:0] rnd_gen();
    logic [GW-1:0] g;
    for (int i = 0; i < GW / 32; i++) g[i*32 +: 32] = $urandom;
    return g;
  endfunction

  task automatic load_gen(input logic [GW-1:0] g);
    @(negedge clk) gen_in = g; gen_load = 1;
    @(negedge clk) gen_load = 0;
    m_gen = g;
    chk(gen_out == g, "R2 idle genome load mismatch");
  endtask

  task automatic do_seed(input logic [15:0] s);
    @(negedge clk) seed_val = s; seed_load = 1;
    @(negedge clk) seed_load = 0;
    m_lfsr = (s == 16'd0) ? 16'hACE1 : s;
  endtask

  // inject: 0 none, 1 start while busy (R7), 2 gen_load while busy (R2), 3 seed_load while busy (R8)
  task automatic run(input int inject);
    int cnt, exp_cyc, ncyc, guard;
    logic [15:0] l;
    l = m_lfsr;
    cnt = pick(l);
    l = step(l);
    exp_cyc = 0;
    while (cnt > 0) begin
      if (int'(l[9:0]) < GW) begin m_gen[l[9:0]] = ~m_gen[l[9:0]]; cnt--; end
      l = step(l);
      exp_cyc++;
    end
    m_lfsr = l;
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
    ncyc = 0; guard = 0;
    while (busy && guard < 5000) begin
      if (ncyc == 0) begin
        if (inject == 1) start = 1;
        if (inject == 2) begin gen_in = ~gen_out; gen_load = 1; end
        if (inject == 3) begin seed_val = 16'h1234; seed_load = 1; end
      end
      ncyc++; guard++;
      @(negedge clk);
      start = 0; gen_load = 0; seed_load = 0;
    end
    chk(ncyc == exp_cyc, $sformatf("R3 R5 busy cycles inj=%0d actual=%0d expected=%0d", inject, ncyc, exp_cyc));
    chk(done === 1'b1, $sformatf("R6 done after last flip actual=%b expected=1", done));
    chk(gen_out == m_gen, $sformatf("R5 R7 R8 genome after run inj=%0d actual=%h expected=%h", inject, gen_out, m_gen));
    @(negedge clk);
    chk(done === 1'b0 && busy === 1'b0, $sformatf("R6 done one cycle actual done=%b busy=%b expected 0 0", done, busy));
  endtask

  initial begin
    void'($urandom(32'd7));
    m_lfsr = 16'hACE1; m_gen = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(gen_out == '0 && busy === 1'b0 && done === 1'b0,
        $sformatf("R1 reset state actual busy=%b done=%b expected 0 0", busy, done));
    // R1: default seed observed through first run
    load_gen(rnd_gen());
    run(0);
    // R8 zero seed substitutes the default constant
    load_gen(rnd_gen());
    do_seed(16'h0000);
    run(0);
    // R8 seed_load beats start in the same cycle
    @(negedge clk) seed_val = 16'h00F1; seed_load = 1; start = 1;
    @(negedge clk) seed_load = 0; start = 0;
    m_lfsr = 16'h00F1;
    chk(busy === 1'b0, $sformatf("R8 start dropped with seed_load actual busy=%b expected 0", busy));
    run(0);
    // all-ones genome and pattern edge cases
    load_gen('1);
    do_seed(16'hFFFF);
    run(0);
    // ignored inputs while busy
    for (int k = 1; k <= 3; k++) begin
      load_gen(rnd_gen());
      run(k);
    end
    // random runs
    for (int i = 0; i < 40; i++) begin
      if (i % 4 == 0) load_gen(rnd_gen());
      if (i % 5 == 0) do_seed(16'($urandom));
      run(i % 4);
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule